// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Core

This block takes eight asynchronous request lines and picks which one the processor serves next. Each line passes through a two-stage synchronizer. It then sets a bit in the pending-request register, either on a fresh rising transition (edge mode) or while the line is held high (level mode). A priority resolver compares the unmasked pending requests with the levels already in service and raises `int_out` when a request outranks all of them. Priority is circular. A single "lowest level" pointer fixes the order, and the level just above the pointer wins.

The processor answers with two low pulses on `inta_n`. The first pulse moves the winning request from the pending register into the in-service register and leaves the vector bus undriven. During the second pulse the core drives an 8-bit vector. Its upper five bits are the programmed base and its lower three bits are the level number. In-service bits are cleared in one of two ways: automatically at the end of the second pulse, or by decoded end-of-service commands. The same commands can also move the priority pointer, either once or automatically after every acknowledge. The pending and in-service registers are brought out for status reads.

Top module: `irq_prio_core`

## Requirements
- R1: While reset is held and right after it is released, `irr`, `isr`, `int_out` and `vec_oe` are all zero, and the lowest-priority level is 7, so level 0 is the highest.
- R2: In edge mode (`level_mode`=0), an `irr` bit is set at the third rising clock edge after its line goes high and stays set until that level is acknowledged. A line that is high when reset is released does not raise a request, and a line that stays high after being acknowledged does not raise it again.
- R3: In level mode (`level_mode`=1), each `irr` bit follows its synchronized line, with the same three-edge delay when the line rises and when it falls.
- R4: The priority order is circular. With lowest level L, the highest level is (L+1) mod 8, and rank rises by one per level, wrapping modulo 8.
- R5: `int_out` is high exactly when some unmasked pending request outranks the highest-priority bit set in `isr`, or when `isr` is empty and any unmasked request is pending.
- R6: A line whose `mask` bit is 1 still sets its `irr` bit but cannot cause `int_out`.
- R7: At the clock edge that samples the first low of `inta_n`, the highest-ranked unmasked pending level is cleared in `irr` and set in `isr`. `vec_oe` stays 0 throughout the first pulse.
- R8: From the edge that samples the second low of `inta_n` until the edge that samples its release, `vec_oe` is 1 and `vec_out` = {`vec_base`, level}. If nothing was eligible at the first pulse, the level is 7 and `isr` is unchanged.
- R9: With `auto_eoi`=1, the acknowledged `isr` bit clears at the edge that samples `inta_n` returning high after the second pulse. With `auto_eoi`=0, an `isr` bit stays set until an end-of-service command clears it.
- R10: Command code 001 (non-specific end of service) clears the highest-ranked `isr` bit. Code 011 (specific) clears `isr[cmd_level]`.
- R11: Code 101 clears the highest-ranked `isr` bit and makes that level the lowest. Code 111 clears `isr[cmd_level]` and makes `cmd_level` the lowest. Code 110 makes `cmd_level` the lowest without touching `isr`.
- R12: Code 100 turns on automatic rotation, which makes each acknowledged level the lowest at the end of its second pulse. Code 000 turns it off.
- R13: Code 010 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Asynchronous request lines |
| inta_n | input | 1 | Active-low acknowledge strobe, synchronous to `clk` |
| mask | input | 8 | Per-level mask, 1 blocks `int_out` |
| level_mode | input | 1 | 1 = level-sensitive, 0 = rising-edge requests |
| auto_eoi | input | 1 | 1 = clear the in-service bit at the end of the acknowledge |
| vec_base | input | 5 | Upper bits of the returned vector |
| cmd_valid | input | 1 | One-cycle strobe for `cmd_code` |
| cmd_code | input | 3 | End-of-service / rotation command code |
| cmd_level | input | 3 | Level operand for the specific commands |
| int_out | output | 1 | Interrupt request to the processor |
| vec_oe | output | 1 | Vector bus drive enable |
| vec_out | output | 8 | Vector value, zero when not driven |
| irr | output | 8 | Pending-request register |
| isr | output | 8 | In-service register |

## Verification
A request becomes visible in `irr` and `int_out` at the third rising edge after the line changes, so the bench waits three clocks after every change on `req_in` and samples on the falling edge that follows. The effects of an acknowledge pulse and of a command show up one edge after the edge that samples them. The bench therefore walks `inta_n` and `cmd_valid` one falling edge at a time and reads `isr`, `irr`, `vec_oe` and `vec_out` exactly one edge after each step. The vector is read while the second pulse is still low, and the automatic clear is checked after the release edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    CMD_ROT_AUTO_CLR = 3'b000,
    CMD_EOI_NS       = 3'b001,
    CMD_NOP          = 3'b010,
    CMD_EOI_SP       = 3'b011,
    CMD_ROT_AUTO_SET = 3'b100,
    CMD_ROT_NS       = 3'b101,
    CMD_SET_PRI      = 3'b110,
    CMD_ROT_SP       = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_ONE  = 2'd1,
    ACK_TWO  = 2'd2
  } ack_e;

endpackage

// File: rtl/irq_sync.sv
// Two-stage synchronizer per line plus rising-edge detection. Edges are
// suppressed until the chain holds real samples, so a line that is high when
// reset is released never looks like a fresh transition.
module irq_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] s1_q, s2_q, prev_q;
  logic [1:0]   cnt_q, cnt_d;
  logic         settled;

  assign settled = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!settled) cnt_d = cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g]   <= 1'b0;
        s2_q[g]   <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        s1_q[g]   <= d[g];
        s2_q[g]   <= s1_q[g];
        prev_q[g] <= s2_q[g];
      end
    end
    assign rise[g] = s2_q[g] & ~prev_q[g] & settled;
  end

  assign lvl = s2_q;

endmodule

// File: rtl/irq_pick.sv
// Finds the highest-ranked set bit of a vector under circular priority:
// level lo+1 ranks first and level lo ranks last. N must be a power of two.
module irq_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] lo,
  output logic          any,
  output logic [LW-1:0] lvl
);

  logic [LW-1:0] idx;

  always_comb begin
    any = 1'b0;
    lvl = '0;
    idx = '0;
    for (int r = N - 1; r >= 0; r--) begin
      idx = lo + LW'(1) + LW'(r);
      if (vec[idx]) begin
        any = 1'b1;
        lvl = idx;
      end
    end
  end

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_pkg::*;
#(
  parameter  int N_LVL = 8,
  parameter  int VEC_W = 8,
  localparam int LW    = $clog2(N_LVL),
  localparam int BW    = VEC_W - LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] req_in,
  input  logic             inta_n,
  input  logic [N_LVL-1:0] mask,
  input  logic             level_mode,
  input  logic             auto_eoi,
  input  logic [BW-1:0]    vec_base,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [LW-1:0]    cmd_level,
  output logic             int_out,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_out,
  output logic [N_LVL-1:0] irr,
  output logic [N_LVL-1:0] isr
);

  logic [N_LVL-1:0] sync_lvl, sync_rise, pend;
  logic [N_LVL-1:0] irr_q, irr_d, isr_q, isr_d;
  logic [LW-1:0]    low_q, low_d, ack_lvl_q, ack_lvl_d;
  logic             rauto_q, rauto_d, ack_hit_q, ack_hit_d, inta_q;
  ack_e             st_q, st_d;
  logic             pend_any, isr_any, inta_fall, inta_rise;
  logic [LW-1:0]    pend_lvl, isr_lvl;

  function automatic logic [LW-1:0] rank_of(input logic [LW-1:0] l,
                                            input logic [LW-1:0] lo);
    return l - lo - LW'(1);
  endfunction

  irq_sync #(.N(N_LVL)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(req_in), .lvl(sync_lvl), .rise(sync_rise)
  );

  assign pend = irr_q & ~mask;

  irq_pick #(.N(N_LVL), .LW(LW)) i_pick_pend (
    .vec(pend), .lo(low_q), .any(pend_any), .lvl(pend_lvl)
  );

  irq_pick #(.N(N_LVL), .LW(LW)) i_pick_isr (
    .vec(isr_q), .lo(low_q), .any(isr_any), .lvl(isr_lvl)
  );

  assign inta_fall = ~inta_n & inta_q;
  assign inta_rise = inta_n & ~inta_q;

  always_comb begin
    irr_d     = level_mode ? sync_lvl : (irr_q | sync_rise);
    isr_d     = isr_q;
    low_d     = low_q;
    rauto_d   = rauto_q;
    st_d      = st_q;
    ack_lvl_d = ack_lvl_q;
    ack_hit_d = ack_hit_q;

    case (st_q)
      ACK_IDLE: if (inta_fall) begin
        st_d      = ACK_ONE;
        ack_hit_d = pend_any;
        ack_lvl_d = pend_any ? pend_lvl : '1;
        if (pend_any) begin
          irr_d[pend_lvl] = 1'b0;
          isr_d[pend_lvl] = 1'b1;
        end
      end
      ACK_ONE: if (inta_fall) st_d = ACK_TWO;
      ACK_TWO: if (inta_rise) begin
        st_d = ACK_IDLE;
        if (ack_hit_q && auto_eoi) isr_d[ack_lvl_q] = 1'b0;
        if (ack_hit_q && rauto_q)  low_d = ack_lvl_q;
      end
      default: st_d = ACK_IDLE;
    endcase

    if (cmd_valid) begin
      case (cmd_e'(cmd_code))
        CMD_EOI_NS: if (isr_any) isr_d[isr_lvl] = 1'b0;
        CMD_EOI_SP: isr_d[cmd_level] = 1'b0;
        CMD_ROT_NS: if (isr_any) begin
          isr_d[isr_lvl] = 1'b0;
          low_d          = isr_lvl;
        end
        CMD_ROT_SP: begin
          isr_d[cmd_level] = 1'b0;
          low_d            = cmd_level;
        end
        CMD_SET_PRI:      low_d   = cmd_level;
        CMD_ROT_AUTO_SET: rauto_d = 1'b1;
        CMD_ROT_AUTO_CLR: rauto_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q     <= '0;
      isr_q     <= '0;
      low_q     <= '1;
      rauto_q   <= 1'b0;
      st_q      <= ACK_IDLE;
      ack_lvl_q <= '0;
      ack_hit_q <= 1'b0;
      inta_q    <= 1'b1;
    end else begin
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      low_q     <= low_d;
      rauto_q   <= rauto_d;
      st_q      <= st_d;
      ack_lvl_q <= ack_lvl_d;
      ack_hit_q <= ack_hit_d;
      inta_q    <= inta_n;
    end
  end

  assign int_out = pend_any &
                   (~isr_any | (rank_of(pend_lvl, low_q) < rank_of(isr_lvl, low_q)));
  assign vec_oe  = (st_q == ACK_TWO);
  assign vec_out = vec_oe ? {vec_base, ack_lvl_q} : '0;
  assign irr     = irr_q;
  assign isr     = isr_q;

  // R6: the interrupt line only rises for an unmasked pending request
  a_r6_mask_no_int: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  // R7: first pulse moves the resolver's winner into service
  a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ACK_IDLE && inta_fall && pend_any && !cmd_valid)
      |=> isr[$past(pend_lvl)]);

  // R9: without auto clear, in-service bits drop only under a command
  a_r9_isr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !auto_eoi) |=> ((isr & $past(isr)) == $past(isr)));

  // R11: set-priority command lands in the pointer one edge later
  a_r11_set_pri: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_SET_PRI) |=> (low_q == $past(cmd_level)));

  // R8: a driven vector always carries the programmed base
  a_r8_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec_out[VEC_W-1:LW] == vec_base));

endmodule

// File: tb/test_irq_prio_core.sv
`timescale 1ns/1ps
module test_irq_prio_core;

  logic       clk = 1'b0;
  logic       rst_n, inta_n, level_mode, auto_eoi, cmd_valid;
  logic [7:0] req_in, mask, vec_out, irr, isr;
  logic [4:0] vec_base;
  logic [2:0] cmd_code, cmd_level;
  logic       int_out, vec_oe;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  irq_prio_core i_irq_prio_core (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .inta_n(inta_n), .mask(mask),
    .level_mode(level_mode), .auto_eoi(auto_eoi), .vec_base(vec_base),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_level(cmd_level),
    .int_out(int_out), .vec_oe(vec_oe), .vec_out(vec_out), .irr(irr), .isr(isr)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_req(input logic [7:0] r);
    req_in = r;
    tick(3);
  endtask

  task automatic cmd(input logic [2:0] c, input logic [2:0] l);
    cmd_code = c; cmd_level = l; cmd_valid = 1'b1;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  task automatic ack(output logic [7:0] vv);
    inta_n = 1'b0; tick(1);
    chk("R7 no drive on first pulse", vec_oe, 0);
    inta_n = 1'b1; tick(1);
    inta_n = 1'b0; tick(1);
    chk("R8 drive on second pulse", vec_oe, 1);
    vv = vec_out;
    inta_n = 1'b1; tick(1);
  endtask

  function automatic logic [7:0] vexp(input int lvl);
    return {vec_base, 3'(lvl)};
  endfunction

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_in = 8'h10; inta_n = 1'b1; mask = 8'h00;
    level_mode = 1'b0; auto_eoi = 1'b0; vec_base = 5'h04;
    cmd_valid = 1'b0; cmd_code = 3'b010; cmd_level = 3'd0;
    tick(3);
    chk("R1 irr in reset", irr, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 isr after reset", isr, 0);
    chk("R1 int after reset", int_out, 0);
    chk("R1 vec_oe after reset", vec_oe, 0);
    tick(5);
    chk("R2 high at reset gives no request", irr, 0);
    set_req(8'h00);

    // single level sweep with varying bases
    for (int i = 0; i < 8; i++) begin
      vec_base = 5'(i * 3 + 1);
      set_req(8'(1 << i));
      chk("R2 edge request", irr, 1 << i);
      chk("R5 int on lone request", int_out, 1);
      ack(v);
      chk("R7 isr set", isr, 1 << i);
      chk("R7 irr cleared", irr, 0);
      chk("R8 vector", v, vexp(i));
      chk("R9 isr held without auto", isr, 1 << i);
      cmd(3'b001, 3'd0);
      chk("R10 non-specific clears", isr, 0);
      chk("R2 held line no re-request", irr, 0);
      chk("R5 int idle", int_out, 0);
      set_req(8'h00);
    end
    vec_base = 5'h04;

    // priority order for every lowest level (R4)
    for (int l = 0; l < 8; l++) begin
      cmd(3'b110, 3'(l));
      set_req(8'hFF);
      for (int k = 0; k < 8; k++) begin
        ack(v);
        chk("R4 circular order", v, vexp((l + 1 + k) % 8));
        cmd(3'b001, 3'd0);
      end
      chk("R4 all served", int_out, 0);
      set_req(8'h00);
    end
    cmd(3'b110, 3'd7);

    // nesting
    set_req(8'h08);
    ack(v);
    chk("R7 level 3 served", v, vexp(3));
    set_req(8'h28);
    chk("R5 lower rank held off", int_out, 0);
    set_req(8'h2A);
    chk("R5 higher rank interrupts", int_out, 1);
    ack(v);
    chk("R5 nested vector", v, vexp(1));
    chk("R7 two in service", isr, 8'h0A);
    cmd(3'b001, 3'd0);
    chk("R10 clears highest only", isr, 8'h08);
    cmd(3'b010, 3'd3);
    chk("R13 nop isr", isr, 8'h08);
    chk("R13 nop irr", irr, 8'h20);
    cmd(3'b011, 3'd3);
    chk("R10 specific clears", isr, 0);
    chk("R5 pending now wins", int_out, 1);
    ack(v);
    chk("R8 level 5 vector", v, vexp(5));
    cmd(3'b001, 3'd0);
    set_req(8'h00);

    // masking and spurious acknowledge
    mask = 8'h04;
    set_req(8'h04);
    chk("R6 masked still recorded", irr, 8'h04);
    chk("R6 masked no int", int_out, 0);
    ack(v);
    chk("R8 spurious vector", v, vexp(7));
    chk("R8 spurious isr unchanged", isr, 0);
    chk("R6 masked request kept", irr, 8'h04);
    mask = 8'h00;
    tick(1);
    chk("R6 unmask raises int", int_out, 1);
    ack(v);
    chk("R6 unmasked served", v, vexp(2));
    cmd(3'b001, 3'd0);
    set_req(8'h00);

    // automatic clear
    auto_eoi = 1'b1;
    set_req(8'h40);
    ack(v);
    chk("R9 auto vector", v, vexp(6));
    chk("R9 auto clears isr", isr, 0);
    set_req(8'h00);

    // automatic rotation
    cmd(3'b100, 3'd0);
    set_req(8'h10);
    ack(v);
    chk("R12 first", v, vexp(4));
    set_req(8'h00);
    set_req(8'h28);
    ack(v);
    chk("R12 rotated order", v, vexp(5));
    ack(v);
    chk("R12 remaining", v, vexp(3));
    cmd(3'b000, 3'd0);
    set_req(8'h00);
    set_req(8'h14);
    ack(v);
    chk("R12 off: 4 ranks first", v, vexp(4));
    set_req(8'h00);
    set_req(8'h30);
    ack(v);
    chk("R12 off: no rotation", v, vexp(4));
    ack(v);
    auto_eoi = 1'b0;
    cmd(3'b110, 3'd7);
    set_req(8'h00);

    // rotate on non-specific
    set_req(8'h04);
    ack(v);
    cmd(3'b101, 3'd0);
    chk("R11 rotate ns clears", isr, 0);
    set_req(8'h00);
    set_req(8'h0A);
    ack(v);
    chk("R11 rotate ns order", v, vexp(3));
    cmd(3'b001, 3'd0);
    ack(v);
    chk("R11 rotate ns next", v, vexp(1));
    cmd(3'b001, 3'd0);
    set_req(8'h00);

    // rotate on specific
    cmd(3'b111, 3'd6);
    set_req(8'h81);
    ack(v);
    chk("R11 rotate sp order", v, vexp(7));
    chk("R5 lower rank after rotate", int_out, 0);
    cmd(3'b011, 3'd7);
    chk("R10 specific 7", isr, 0);
    chk("R5 int after clear", int_out, 1);
    ack(v);
    chk("R11 rotate sp next", v, vexp(0));
    cmd(3'b001, 3'd0);
    cmd(3'b110, 3'd7);
    set_req(8'h00);

    // level mode
    level_mode = 1'b1;
    set_req(8'h20);
    chk("R3 level follows high", irr, 8'h20);
    set_req(8'h00);
    chk("R3 level follows low", irr, 0);
    level_mode = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule